// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block is the digital mode logic of a high-speed bus transceiver. Two host control pins are synchronized: `stb_pin` is the wake/active select and `en_pin` is the enable. Together with a small set of internal condition flags, they select one of five operating modes:

- normal
- listen-only
- standby
- sleep-request (the timed route into sleep)
- sleep

From the current mode the block drives four controls for the analog front end:

- the transmitter enable;
- the bus bias select, mid-supply or ground;
- the common-mode split output enable;
- the enable of the external regulator (inhibit).

The condition inputs arrive already debounced:

- `supply_uv_req` sets the supply-undervoltage flag;
- `pwr_on_req` sets the power-on flag;
- `wake_req` requests the wake flag;
- `batt_uv` is a battery-undervoltage level.

Sleep is reached in only two ways. The first is holding the sleep-request pin pattern for `HOLD_CYC` clock cycles. The second is the supply-undervoltage flag, which forces sleep at once.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: `mode_o` uses this encoding: normal=0, listen-only=1, standby=2, sleep-request=3, sleep=4. Both control pins pass a two-stage synchronizer. A pin pattern applied before clock edge k acts on `mode_o` after edge k+2.
- R2: With `stb_pin`=0 and `en_pin`=0 the block enters standby from any mode except sleep. Sleep is kept under that pattern while the power-on and wake flags are clear.
- R3: With `stb_pin`=0 and `en_pin`=1 the block enters sleep-request only when the power-on and wake flags are both clear. Otherwise it goes to standby.
- R4: After an unbroken stay of exactly `HOLD_CYC` cycles in sleep-request, the block enters sleep. The dwell count restarts on every entry.
- R5: Sleep-request is left before sleep if the pin pattern changes, or if the wake flag, the power-on flag or `batt_uv` becomes active. This includes the last cycle of the dwell.
- R6: One cycle after the supply-undervoltage flag sets, the block is in sleep, from any mode. It stays in sleep while that flag is set, whatever the pins do.
- R7: From sleep, `stb_pin`=1 moves the block to the pin-selected mode, or to standby if `batt_uv` is 1. With `stb_pin`=0, a set power-on or wake flag moves it to standby.
- R8: While `batt_uv` is 1, every mode except sleep falls back to standby in the next cycle. When `batt_uv` is released, the pin-selected mode returns in the next cycle.
- R9: The four outputs depend on the mode as follows:
  - `tx_en` is 1 only in normal.
  - `bias_mid` and `split_en` are 1 only in normal and listen-only.
  - `inh_en` is 0 only in sleep.
- R10: Entering normal clears the power-on and wake flags. A `wake_req` is accepted only in standby, sleep-request or sleep, and is ignored in normal and listen-only.
- R11: A `pwr_on_req`, or an accepted `wake_req`, clears the supply-undervoltage flag. It wins over a `supply_uv_req` in the same cycle.
- R12: Reset leaves the block in standby with the power-on flag set. The wake and supply-undervoltage flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb_pin | input | 1 | Wake/active select pin, asynchronous |
| en_pin | input | 1 | Enable pin, asynchronous |
| batt_uv | input | 1 | Battery undervoltage level, synchronous |
| pwr_on_req | input | 1 | Sets the power-on flag |
| wake_req | input | 1 | Local or remote wake request |
| supply_uv_req | input | 1 | Sets the supply-undervoltage flag |
| tx_en | output | 1 | Transmitter enable |
| bias_mid | output | 1 | Bus bias at mid-supply (0 selects ground) |
| split_en | output | 1 | Split output enable |
| inh_en | output | 1 | External regulator enable |
| mode_o | output | 3 | Current mode code |

## Verification
The critical overlap is the expiry of the sleep-request dwell with a flag being set in the same cycle. The bench times a wake request so that the flag registers on the edge just before expiry. It then expects standby rather than sleep. It repeats the timing with a supply-undervoltage request and expects sleep, since that flag has the higher priority. Constrained random pin, level and event traffic is compared every cycle against a bench-side mode model. This model covers further chance collisions of flags, pin edges and dwell ends.

// File: rtl/xm_pkg.sv
package xm_pkg;

   typedef enum logic [2:0] {
      MD_NORMAL  = 3'd0,
      MD_LISTEN  = 3'd1,
      MD_STANDBY = 3'd2,
      MD_GTS     = 3'd3,
      MD_SLEEP   = 3'd4
   } xm_mode_e;

   typedef struct packed {
      logic pon;
      logic wake;
      logic uvs;
   } xm_flags_t;

   typedef struct packed {
      logic tx;
      logic bias;
      logic split;
      logic inh;
   } xm_drv_t;

   function automatic xm_drv_t xm_decode(xm_mode_e m);
      xm_drv_t d;
      d.tx    = (m == MD_NORMAL);
      d.bias  = (m == MD_NORMAL) || (m == MD_LISTEN);
      d.split = d.bias;
      d.inh   = (m != MD_SLEEP);
      return d;
   endfunction

endpackage

// File: rtl/xm_sync.sv
module xm_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("xm_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("xm_sync: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stg
      logic [WIDTH-1:0] q;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= g_stg[i-1].q;
         end
      end
   end

   assign q_o = g_stg[STAGES-1].q;

endmodule

// File: rtl/xm_hold_timer.sv
module xm_hold_timer #(
   parameter int HOLD_CYC = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_gts_i,
   output logic done_o
);

   localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

   logic [CW-1:0] cnt_q;

   assign done_o = in_gts_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (in_gts_i && !done_o) cnt_q <= cnt_q + CW'(1);
      else                          cnt_q <= '0;
   end

   // R4: the count never passes the last dwell cycle
   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) < HOLD_CYC);

   // R4: outside the request mode the dwell count is restarted
   p_cnt_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_gts_i |=> cnt_q == '0);

endmodule

// File: rtl/xm_flags.sv
module xm_flags
   import xm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pon_set_i,
   input  logic      wake_req_i,
   input  logic      uvs_set_i,
   input  xm_mode_e  mode_q_i,
   input  xm_mode_e  mode_d_i,
   output xm_flags_t flg_o
);

   logic      wake_ok;
   logic      enter_norm;
   xm_flags_t flg_q, flg_d;

   assign wake_ok    = wake_req_i && (mode_q_i == MD_STANDBY ||
                                      mode_q_i == MD_GTS ||
                                      mode_q_i == MD_SLEEP);
   assign enter_norm = (mode_d_i == MD_NORMAL) && (mode_q_i != MD_NORMAL);

   always_comb begin
      flg_d = flg_q;
      if (pon_set_i)       flg_d.pon = 1'b1;
      else if (enter_norm) flg_d.pon = 1'b0;

      if (wake_ok)                                flg_d.wake = 1'b1;
      else if (enter_norm)                        flg_d.wake = 1'b0;
      else if (uvs_set_i && !pon_set_i)           flg_d.wake = 1'b0;

      if (pon_set_i || wake_ok) flg_d.uvs = 1'b0;
      else if (uvs_set_i)       flg_d.uvs = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg_q <= '{pon: 1'b1, wake: 1'b0, uvs: 1'b0};
      else        flg_q <= flg_d;
   end

   assign flg_o = flg_q;

   // R11: a power-on or accepted wake event leaves the supply flag clear
   p_uvs_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pon_set_i || wake_ok) |=> !flg_q.uvs);

   // R10: a wake request in an active mode leaves the wake flag clear
   p_wake_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!flg_q.wake && wake_req_i &&
       (mode_q_i == MD_NORMAL || mode_q_i == MD_LISTEN)) |=> !flg_q.wake);

   // R10: entering normal without a new power-on event clears power-on
   p_pon_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_d_i == MD_NORMAL && mode_q_i != MD_NORMAL && !pon_set_i)
      |=> !flg_q.pon);

endmodule

// File: rtl/xm_fsm.sv
module xm_fsm
   import xm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      stb_i,
   input  logic      en_i,
   input  logic      uvb_i,
   input  xm_flags_t flg_i,
   input  logic      hold_done_i,
   output xm_mode_e  mode_q_o,
   output xm_mode_e  mode_d_o
);

   xm_mode_e pin_sel;
   xm_mode_e mode_q, mode_d;
   logic     any_flag;

   assign any_flag = flg_i.pon || flg_i.wake;

   always_comb begin
      if (stb_i)         pin_sel = en_i ? MD_NORMAL : MD_LISTEN;
      else if (!en_i)    pin_sel = MD_STANDBY;
      else if (any_flag) pin_sel = MD_STANDBY;
      else               pin_sel = MD_GTS;
   end

   always_comb begin
      mode_d = pin_sel;
      if (flg_i.uvs) begin
         mode_d = MD_SLEEP;
      end else if (mode_q == MD_SLEEP) begin
         if (stb_i)         mode_d = uvb_i ? MD_STANDBY : pin_sel;
         else if (any_flag) mode_d = MD_STANDBY;
         else               mode_d = MD_SLEEP;
      end else if (uvb_i) begin
         mode_d = MD_STANDBY;
      end else if (mode_q == MD_GTS && pin_sel == MD_GTS && hold_done_i) begin
         mode_d = MD_SLEEP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MD_STANDBY;
      else        mode_q <= mode_d;
   end

   assign mode_q_o = mode_q;
   assign mode_d_o = mode_d;

   // R6: the supply flag forces sleep on the next edge
   p_uvs_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flg_i.uvs |=> mode_q == MD_SLEEP);

   // R4: sleep is reached only from the request mode or by the supply flag
   p_sleep_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MD_SLEEP && mode_q != MD_GTS && !flg_i.uvs)
      |=> mode_q != MD_SLEEP);

   // R3: a set power-on or wake flag keeps the request mode out of reach
   p_gts_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (any_flag && !flg_i.uvs) |=> mode_q != MD_GTS);

   // R8: battery undervoltage drops every awake mode to standby
   p_batt_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (uvb_i && !flg_i.uvs && mode_q != MD_SLEEP) |=> mode_q == MD_STANDBY);

endmodule

// File: rtl/xm_drive.sv
module xm_drive
   import xm_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  xm_mode_e mode_i,
   output xm_drv_t  drv_o
);

   if (OUT_REG) begin : g_reg
      xm_drv_t drv_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) drv_q <= xm_decode(MD_STANDBY);
         else        drv_q <= xm_decode(mode_i);
      end
      assign drv_o = drv_q;
   end else begin : g_comb
      assign drv_o = xm_decode(mode_i);
   end

endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
   import xm_pkg::*;
#(
   parameter int HOLD_CYC    = 10000,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stb_pin,
   input  logic       en_pin,
   input  logic       batt_uv,
   input  logic       pwr_on_req,
   input  logic       wake_req,
   input  logic       supply_uv_req,
   output logic       tx_en,
   output logic       bias_mid,
   output logic       split_en,
   output logic       inh_en,
   output logic [2:0] mode_o
);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("xcvr_mode_ctrl: HOLD_CYC must be at least 1");
   end

   logic [1:0] pins_s;
   xm_flags_t  flg;
   xm_mode_e   mode_q, mode_d;
   logic       hold_done;
   xm_drv_t    drv;

   xm_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({stb_pin, en_pin}),
      .q_o   (pins_s)
   );

   xm_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_gts_i (mode_q == MD_GTS),
      .done_o   (hold_done)
   );

   xm_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .stb_i       (pins_s[1]),
      .en_i        (pins_s[0]),
      .uvb_i       (batt_uv),
      .flg_i       (flg),
      .hold_done_i (hold_done),
      .mode_q_o    (mode_q),
      .mode_d_o    (mode_d)
   );

   xm_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .pon_set_i  (pwr_on_req),
      .wake_req_i (wake_req),
      .uvs_set_i  (supply_uv_req),
      .mode_q_i   (mode_q),
      .mode_d_i   (mode_d),
      .flg_o      (flg)
   );

   xm_drive #(.OUT_REG(OUT_REG)) u_drive (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (OUT_REG ? mode_d : mode_q),
      .drv_o  (drv)
   );

   assign tx_en    = drv.tx;
   assign bias_mid = drv.bias;
   assign split_en = drv.split;
   assign inh_en   = drv.inh;
   assign mode_o   = mode_q;

   // R9: the regulator enable is released exactly in sleep
   p_inh_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      inh_en == (mode_o != 3'd4));

   // R9: the transmitter only drives in normal mode
   p_tx_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |-> (mode_o == 3'd0) && bias_mid && split_en);

endmodule

// File: tb/tb_xcvr_mode_ctrl.sv
module tb_xcvr_mode_ctrl;
   import xm_pkg::*;

   localparam int HOLD = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stb = 1'b0, en = 1'b0, uvb = 1'b0;
   logic       pon_ev = 1'b0, wake_ev = 1'b0, uvs_ev = 1'b0;
   logic       tx_en, bias_mid, split_en, inh_en;
   logic [2:0] mode_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   xcvr_mode_ctrl #(.HOLD_CYC(HOLD)) dut (
      .clk(clk), .rst_n(rst_n), .stb_pin(stb), .en_pin(en),
      .batt_uv(uvb), .pwr_on_req(pon_ev), .wake_req(wake_ev),
      .supply_uv_req(uvs_ev), .tx_en(tx_en), .bias_mid(bias_mid),
      .split_en(split_en), .inh_en(inh_en), .mode_o(mode_o)
   );

   // expected output vector {tx, bias, split, inh} for a mode code
   function automatic logic [3:0] exp_drv(logic [2:0] m);
      return {m == 3'd0, m <= 3'd1, m <= 3'd1, m != 3'd4};
   endfunction

   // reference next mode from requirements R2..R8
   function automatic logic [2:0] ref_next(logic [2:0] cur, logic s, logic e,
                                           logic bu, logic fp, logic fw,
                                           logic fu, logic hd);
      logic [2:0] sel;
      if (s)             sel = e ? 3'd0 : 3'd1;
      else if (!e)       sel = 3'd2;
      else if (fp || fw) sel = 3'd2;
      else               sel = 3'd3;
      if (fu) return 3'd4;
      if (cur == 3'd4) begin
         if (s) return bu ? 3'd2 : sel;
         if (fp || fw) return 3'd2;
         return 3'd4;
      end
      if (bu) return 3'd2;
      if (cur == 3'd3 && sel == 3'd3 && hd) return 3'd4;
      return sel;
   endfunction

   logic [2:0] m_mode;
   logic       m_pon, m_wake, m_uvs;
   int         m_cnt;
   logic [1:0] m_s1, m_s2;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 3'd2; m_pon = 1'b1; m_wake = 1'b0; m_uvs = 1'b0;
         m_cnt = 0; m_s1 = 2'b00; m_s2 = 2'b00;
      end else begin : model_step
         logic [2:0] nm;
         logic       hd, wok, ent;
         hd  = (m_mode == 3'd3) && (m_cnt == HOLD - 1);
         nm  = ref_next(m_mode, m_s2[1], m_s2[0], uvb, m_pon, m_wake, m_uvs, hd);
         wok = wake_ev && (m_mode >= 3'd2);
         ent = (nm == 3'd0) && (m_mode != 3'd0);
         if (pon_ev)   m_pon = 1'b1;
         else if (ent) m_pon = 1'b0;
         if (wok)                      m_wake = 1'b1;
         else if (ent)                 m_wake = 1'b0;
         else if (uvs_ev && !pon_ev)   m_wake = 1'b0;
         if (pon_ev || wok) m_uvs = 1'b0;
         else if (uvs_ev)   m_uvs = 1'b1;
         m_cnt  = (m_mode == 3'd3 && !hd) ? m_cnt + 1 : 0;
         m_mode = nm;
         m_s2   = m_s1;
         m_s1   = {stb, en};
      end
   end

   task automatic want(input logic [2:0] exp, input string tag);
      checks++;
      if (mode_o !== exp || {tx_en, bias_mid, split_en, inh_en} !== exp_drv(exp)) begin
         fails++;
         $display("FAIL %s: mode=%0d drv=%b expected mode=%0d drv=%b",
                  tag, mode_o, {tx_en, bias_mid, split_en, inh_en}, exp, exp_drv(exp));
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic setpins(input logic s, input logic e);
      stb = s; en = e;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      tick(3);
      rst_n = 1'b1;
      tick(1);
      want(3'd2, "R12 reset standby");
      setpins(0, 1); tick(4);
      want(3'd2, "R12 power-on flag set after reset (R3 standby)");
      setpins(1, 1); tick(3);
      want(3'd0, "R1 normal after three edges");
      setpins(0, 1); tick(3);
      want(3'd3, "R3 request mode with flags clear");
      tick(HOLD - 1);
      want(3'd3, "R4 still in request before dwell ends");
      tick(1);
      want(3'd4, "R4 sleep after dwell, R9 inhibit off");
      setpins(0, 0); tick(4);
      want(3'd4, "R2 sleep kept with both pins low");
      setpins(1, 0); tick(3);
      want(3'd1, "R7 sleep left to listen-only");
      setpins(0, 0); tick(3);
      want(3'd2, "R2 standby from listen-only");
      // abort by wake flag
      setpins(0, 1); tick(3);
      want(3'd3, "R3 request entered");
      tick(2);
      wake_ev = 1'b1; tick(1); wake_ev = 1'b0;
      tick(1);
      want(3'd2, "R5 wake flag aborts request");
      tick(3);
      want(3'd2, "R3 wake flag blocks request");
      setpins(1, 1); tick(3);
      want(3'd0, "R10 normal entered");
      setpins(0, 1); tick(3);
      want(3'd3, "R10 flags cleared by normal entry");
      tick(2);
      setpins(0, 0); tick(3);
      want(3'd2, "R5 pin change aborts request");
      setpins(0, 1); tick(3);
      tick(HOLD - 1);
      want(3'd3, "R4 dwell count restarted on entry");
      tick(1);
      want(3'd4, "R4 sleep after full dwell");
      // wake ignored in normal
      setpins(1, 1); tick(3);
      want(3'd0, "R7 sleep left to normal");
      wake_ev = 1'b1; tick(1); wake_ev = 1'b0;
      tick(1);
      setpins(0, 1); tick(3);
      want(3'd3, "R10 wake request in normal ignored");
      // battery undervoltage
      setpins(1, 1); tick(3);
      uvb = 1'b1; tick(1);
      want(3'd2, "R8 battery undervoltage to standby");
      uvb = 1'b0; tick(1);
      want(3'd0, "R8 pin mode restored");
      // supply undervoltage
      uvs_ev = 1'b1; tick(1); uvs_ev = 1'b0;
      tick(1);
      want(3'd4, "R6 forced sleep");
      tick(5);
      want(3'd4, "R6 stb high cannot leave sleep");
      pon_ev = 1'b1; tick(1); pon_ev = 1'b0;
      tick(1);
      want(3'd0, "R11 power-on clears supply flag");
      uvs_ev = 1'b1; pon_ev = 1'b1; tick(1); uvs_ev = 1'b0; pon_ev = 1'b0;
      tick(2);
      want(3'd0, "R11 power-on wins over supply set");
      setpins(0, 1); tick(3);
      want(3'd2, "R3 power-on flag set blocks request");
      // coincidence: wake flag on the last dwell edge
      setpins(1, 1); tick(3);
      setpins(0, 1); tick(3);
      want(3'd3, "R3 request entered");
      tick(HOLD - 2);
      wake_ev = 1'b1; tick(1); wake_ev = 1'b0;
      want(3'd3, "R5 request still held");
      tick(1);
      want(3'd2, "R5 flag at dwell expiry gives standby");
      // coincidence: supply flag on the last dwell edge
      setpins(1, 1); tick(3);
      setpins(0, 1); tick(3);
      tick(HOLD - 2);
      uvs_ev = 1'b1; tick(1); uvs_ev = 1'b0;
      tick(1);
      want(3'd4, "R6 supply flag at dwell expiry gives sleep");
      wake_ev = 1'b1; tick(1); wake_ev = 1'b0;
      tick(1);
      want(3'd2, "R11 accepted wake clears supply flag (R7 standby)");
      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         checks++;
         if (mode_o !== m_mode ||
             {tx_en, bias_mid, split_en, inh_en} !== exp_drv(m_mode)) begin
            fails++;
            $display("FAIL R9 random cycle %0d: mode=%0d drv=%b expected mode=%0d drv=%b",
                     i, mode_o, {tx_en, bias_mid, split_en, inh_en},
                     m_mode, exp_drv(m_mode));
         end
         if ($urandom % 16 == 0) stb = 1'($urandom % 2);
         if ($urandom % 16 == 0) en  = 1'($urandom % 2);
         if ($urandom % 64 == 0) uvb = ~uvb;
         pon_ev  = ($urandom % 97 == 0);
         wake_ev = ($urandom % 23 == 0);
         uvs_ev  = ($urandom % 151 == 0);
      end
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule